// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces, or watches, the two serial timing clocks of a digital audio converter link: a bit clock running at 64 times the sample rate and a frame clock running at the sample rate. Everything runs off the converter's master clock `clk_i`. When `master_i` is high, the block divides the master clock by a ratio chosen through a 2-bit ratio field and drives both serial clocks. When `master_i` is low, the serial clocks come from outside. The block then only checks that they are running.

A power-down flag `pdn_o` tells the downstream converter core when it may run. In master mode it drops on the first master clock edge after reset. In slave mode it stays high until both incoming clocks have shown a steady run of edges. It rises again as soon as either incoming clock stalls.

Top module: `audio_clkgen`

## Requirements
- R1: While `master_i` is low, `bclk_o` and `fclk_o` are held low from the next master clock edge on.
- R2: The ratio field selects the bit-clock divide. Code 00 gives MCLK/4, code 01 gives MCLK/6 and code 10 gives MCLK/8. The bit clock has a 50% duty cycle, so it stays 2, 3 or 4 cycles at each level. After reset the field holds code 10.
- R3: A write (`ratio_wr_i` high) of the reserved code 11 is ignored. The previous divide stays in effect and the clocks are not restarted.
- R4: In master mode `fclk_o` toggles at the falling edge of `bclk_o` that ends every 32nd bit-clock period. This gives 64 bit clocks per frame at a 50% duty cycle, with `fclk_o` low first.
- R5: A write of a valid code, or `master_i` being low, restarts both dividers. After that edge `bclk_o` and `fclk_o` are low and counting starts again from zero with the newly selected ratio.
- R6: In master mode `pdn_o` is low from the first master clock edge after reset.
- R7: In slave mode each incoming clock passes through a two-flop synchronizer, and its rising edges are then counted. A channel becomes active after 4 rising edges, each one arriving within 1024 master clock cycles of the one before. `pdn_o` falls one cycle after both channels are active.
- R8: In slave mode, once 1024 master clock cycles pass with no rising edge on a channel, that channel's edge count clears and `pdn_o` rises. This also means that edges spaced further apart than the timeout never release power-down.
- R9: While `rst_ni` is low, `pdn_o` is high and `bclk_o` and `fclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | High: drive serial clocks; low: monitor external ones |
| ratio_wr_i | input | 1 | Write strobe for the ratio field |
| ratio_i | input | 2 | Ratio code: 00 = 256fs, 01 = 384fs, 10 = 512fs, 11 reserved |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock, 64fs |
| fclk_o | output | 1 | Generated frame clock, 1fs |
| pdn_o | output | 1 | Power-down request to the converter core, active high |

## Verification
A divider phase that is off by even one count shows up on `bclk_o` within one half-period: at most four master clocks. A wrong bit count shifts the next `fclk_o` toggle, which is exposed within one frame of 512 master clocks at most. A stale ratio after an ignored reserved write, or a missed restart, makes the very next output sample differ from the bench's cycle model. A slave edge counter or gap timer in the wrong state moves the `pdn_o` transition away from its exact expected cycle. That shows within one timeout window, about a thousand master clocks.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  typedef enum logic [1:0] {
    RATIO_256  = 2'b00,
    RATIO_384  = 2'b01,
    RATIO_512  = 2'b10,
    RATIO_RSVD = 2'b11
  } ratio_e;

  // master clock cycles per bit clock level
  function automatic logic [2:0] half_period(ratio_e r);
    case (r)
      RATIO_256: return 3'd2;
      RATIO_384: return 3'd3;
      default:   return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/acg_ratio_reg.sv
module acg_ratio_reg
  import audio_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] ratio_i,
  output ratio_e     ratio_o,
  output logic       load_o
);
  ratio_e ratio_q;

  assign load_o = wr_i && (ratio_i != RATIO_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_q <= RATIO_512;
    else if (load_o) ratio_q <= ratio_e'(ratio_i);
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/acg_divider.sv
module acg_divider
  import audio_clk_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  ratio_e ratio_i,
  output logic   bclk_o,
  output logic   fclk_o
);
  localparam int unsigned HALF_FRAME = FRAME_BITS / 2;
  localparam int unsigned BW = $clog2(HALF_FRAME);
  localparam logic [BW-1:0] LAST_BIT = BW'(HALF_FRAME - 1);

  logic [2:0]    ph_q;
  logic [BW-1:0] bit_q;
  logic          bclk_q, fclk_q;
  logic [2:0]    half;

  assign half = half_period(ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else if (clear_i) begin
      ph_q   <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else if (ph_q == half - 3'd1) begin
      ph_q   <= '0;
      bclk_q <= ~bclk_q;
      if (bclk_q) begin  // falling bit clock edge
        if (bit_q == LAST_BIT) begin
          bit_q  <= '0;
          fclk_q <= ~fclk_q;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end else begin
      ph_q <= ph_q + 3'd1;
    end
  end

  assign bclk_o = bclk_q;
  assign fclk_o = fclk_q;
endmodule

// File: rtl/acg_activity.sv
module acg_activity #(
  parameter int unsigned TIMEOUT = 1024,
  parameter int unsigned EDGES   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_ext_i,
  output logic active_o
);
  localparam int unsigned GW = $clog2(TIMEOUT + 1);
  localparam int unsigned EW = $clog2(EDGES + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(TIMEOUT);
  localparam logic [EW-1:0] EDGE_MAX = EW'(EDGES);

  logic [2:0]    sync_q;  // [1:0] synchronizer, [2] edge history
  logic [GW-1:0] gap_q;
  logic [EW-1:0] cnt_q;
  logic          rise, expired;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign expired = (gap_q == GAP_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      gap_q  <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], clk_ext_i};
      if (rise) begin
        gap_q <= '0;
        if (expired)               cnt_q <= EW'(1);
        else if (cnt_q != EDGE_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (!expired) begin
        gap_q <= gap_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign active_o = (cnt_q == EDGE_MAX);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clk_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned TIMEOUT    = 1024,
  parameter int unsigned EDGES      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic       ratio_wr_i,
  input  logic [1:0] ratio_i,
  input  logic       bclk_i,
  input  logic       fclk_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       pdn_o
);
  localparam int unsigned NUM_CH = 2;

  ratio_e            ratio_q;
  logic              load;
  logic              clear;
  logic [NUM_CH-1:0] ext_clk;
  logic [NUM_CH-1:0] act;
  logic              pdn_q;

  acg_ratio_reg u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ratio_wr_i),
    .ratio_i (ratio_i),
    .ratio_o (ratio_q),
    .load_o  (load)
  );

  assign clear = !master_i || load;

  acg_divider #(.FRAME_BITS(FRAME_BITS)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .ratio_i (ratio_q),
    .bclk_o  (bclk_o),
    .fclk_o  (fclk_o)
  );

  assign ext_clk = {fclk_i, bclk_i};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mon
    acg_activity #(.TIMEOUT(TIMEOUT), .EDGES(EDGES)) u_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clk_ext_i (ext_clk[g]),
      .active_o  (act[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pdn_q <= 1'b1;
    else         pdn_q <= master_i ? 1'b0 : ~(&act);
  end

  assign pdn_o = pdn_q;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic       ratio_wr_i,
  input logic       bclk_o,
  input logic       fclk_o,
  input logic       pdn_o,
  input logic [1:0] ratio_q
);
  logic       prev_q;
  logic [3:0] run_q;

  // cycles the bit clock has held its level; a restart may stretch one low phase by a cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= bclk_o;
      if (!master_i || ratio_wr_i || (bclk_o != prev_q)) run_q <= '0;
      else if (run_q != 4'hf)                            run_q <= run_q + 4'd1;
    end
  end

  assert_slave_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bclk_o && !fclk_o));

  assert_half_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 4'd4);

  assert_ratio_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q != 2'b11);

  assert_fclk_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fclk_o != $past(fclk_o)) |-> ($fell(bclk_o) || !fclk_o));

  assert_master_awake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> !pdn_o);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_i   (master_i),
  .ratio_wr_i (ratio_wr_i),
  .bclk_o     (bclk_o),
  .fclk_o     (fclk_o),
  .pdn_o      (pdn_o),
  .ratio_q    (ratio_q)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, master, wr;
  logic [1:0] code;
  logic       ext_b = 1'b0, ext_f = 1'b0;
  logic       bclk, fclk, pdn;

  audio_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .ratio_wr_i(wr), .ratio_i(code),
    .bclk_i(ext_b), .fclk_i(ext_f), .bclk_o(bclk), .fclk_o(fclk), .pdn_o(pdn)
  );

  int checks = 0, fails = 0;
  bit done = 0, chk_on = 0;

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // external clock sources for slave mode
  int b_half = 0, f_half = 0, b_cnt = 0, f_cnt = 0;
  always @(negedge clk) begin
    if (b_half > 0) begin b_cnt++; if (b_cnt >= b_half) begin b_cnt = 0; ext_b = ~ext_b; end end
    if (f_half > 0) begin f_cnt++; if (f_cnt >= f_half) begin f_cnt = 0; ext_f = ~ext_f; end end
  end

  // behavioural reference model
  int m_half = 4, n = 0;
  bit e_b = 0, e_f = 0, e_p = 1;
  bit q1[2], q2[2], q3[2];
  int gap[2], cnt[2];
  bit ld, rise, expd, inb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_half = 4; n = 0; e_b = 0; e_f = 0; e_p = 1;
      for (int c = 0; c < 2; c++) begin q1[c] = 0; q2[c] = 0; q3[c] = 0; gap[c] = 0; cnt[c] = 0; end
    end else begin
      e_p = master ? 1'b0 : !((cnt[0] == 4) && (cnt[1] == 4));
      ld = wr && (code != 2'b11);
      if (ld) m_half = 2 + int'(code);
      if (!master || ld) n = 0; else n++;
      e_b = ((n / m_half) % 2) == 1;
      e_f = (((n / (2 * m_half)) / 32) % 2) == 1;
      for (int c = 0; c < 2; c++) begin
        rise = q2[c] && !q3[c];
        expd = gap[c] == 1024;
        if (rise) begin
          gap[c] = 0;
          if (expd) cnt[c] = 1; else if (cnt[c] != 4) cnt[c]++;
        end else if (!expd) gap[c]++;
        else cnt[c] = 0;
        inb = (c == 0) ? ext_b : ext_f;
        q3[c] = q2[c]; q2[c] = q1[c]; q1[c] = inb;
      end
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      chk("R2", int'(bclk), int'(e_b), "bclk_o vs model");
      chk("R4", int'(fclk), int'(e_f), "fclk_o vs model");
      chk("R7", int'(pdn),  int'(e_p), "pdn_o vs model");
    end
  end

  task automatic write_ratio(input logic [1:0] c);
    wr = 1'b1; code = c;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bclk_levels(output int h, output int l);
    h = 0; l = 0;
    while (bclk !== 1'b0) @(negedge clk);
    while (bclk !== 1'b1) @(negedge clk);
    while (bclk === 1'b1) begin h++; @(negedge clk); end
    while (bclk === 1'b0) begin l++; @(negedge clk); end
  endtask

  task automatic fclk_high(output int h);
    h = 0;
    while (fclk !== 1'b0) @(negedge clk);
    while (fclk !== 1'b1) @(negedge clk);
    while (fclk === 1'b1) begin h++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int h, l;
    rst_n = 1'b0; master = 1'b1; wr = 1'b0; code = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9", int'(pdn), 1, "pdn_o in reset");
    chk("R9", int'(bclk), 0, "bclk_o in reset");
    chk("R9", int'(fclk), 0, "fclk_o in reset");
    rst_n = 1'b1; chk_on = 1;
    @(negedge clk);
    chk("R6", int'(pdn), 0, "pdn_o after first master edge");

    // default ratio 512fs
    bclk_levels(h, l);
    chk("R2", h, 4, "512fs high cycles"); chk("R2", l, 4, "512fs low cycles");
    fclk_high(h);
    chk("R4", h, 256, "512fs frame half length");

    // restart on valid write while frame clock high
    while (fclk !== 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    write_ratio(2'b00);
    chk("R5", int'(bclk), 0, "bclk_o after restart");
    chk("R5", int'(fclk), 0, "fclk_o after restart");
    bclk_levels(h, l);
    chk("R2", h, 2, "256fs high cycles"); chk("R2", l, 2, "256fs low cycles");
    fclk_high(h);
    chk("R4", h, 128, "256fs frame half length");

    // divide by 6
    write_ratio(2'b01);
    bclk_levels(h, l);
    chk("R2", h, 3, "384fs high cycles"); chk("R2", l, 3, "384fs low cycles");
    fclk_high(h);
    chk("R4", h, 192, "384fs frame half length");

    // reserved code ignored
    repeat (7) @(negedge clk);
    write_ratio(2'b11);
    bclk_levels(h, l);
    chk("R3", h, 3, "high cycles after reserved write");
    chk("R3", l, 3, "low cycles after reserved write");
    repeat (600) @(negedge clk);

    // mode change restarts
    master = 1'b0;
    @(negedge clk);
    chk("R1", int'(bclk), 0, "bclk_o in slave");
    chk("R1", int'(fclk), 0, "fclk_o in slave");
    repeat (10) @(negedge clk);
    master = 1'b1;
    @(negedge clk);
    chk("R5", int'(bclk), 0, "bclk_o after mode restart");
    repeat (400) @(negedge clk);

    // slave: wake on clock activity
    master = 1'b0; b_half = 4; f_half = 256;
    repeat (100) @(negedge clk);
    chk("R7", int'(pdn), 1, "pdn_o before enough edges");
    repeat (2900) @(negedge clk);
    chk("R7", int'(pdn), 0, "pdn_o with both clocks running");
    chk("R1", int'(bclk), 0, "bclk_o held in slave");

    // stalled bit clock
    b_half = 0;
    repeat (1200) @(negedge clk);
    chk("R8", int'(pdn), 1, "pdn_o after bit clock stall");

    // frame edges too sparse
    b_half = 4; f_half = 600;
    repeat (6000) @(negedge clk);
    chk("R8", int'(pdn), 1, "pdn_o with sparse frame edges");

    f_half = 256;
    repeat (2600) @(negedge clk);
    chk("R7", int'(pdn), 0, "pdn_o after recovery");

    finish_run();
  end
endmodule